// File: doc/BRIEF.md
# Iterative Counted Logical Right Shifter

This block performs a logical right shift of a 32-bit word. It uses a loop of single-bit steps, not a combinational barrel. A 5-bit down-counter holds the remaining shift distance. Each working clock moves the data register one place toward bit 0, feeds a zero in at the top, and lowers the counter by one. The loop ends when the counter reads zero, and the block then presents the result for one clock.

The distance comes from two places. A start pulse first loads the 5-bit immediate distance. If that value is zero, the next step loads the 5-bit register-supplied distance instead. The data word is captured in a separate step after both count steps. When both distances are zero the word comes out unchanged.

The surrounding logic keeps the operand and the register-supplied distance stable from the start pulse until done. These inputs are sampled two and one steps after start.

Top module: `iter_shr`

## Requirements
- R1: After synchronous active-high reset, busy is 0, done is 0 and result is 0.
- R2: A start pulse sampled while idle begins an operation, and busy is 1 from the next clock until the clock in which done is 1.
- R3: When the immediate distance is nonzero, the register-supplied distance has no effect on the result.
- R4: When the immediate distance is zero, the shift distance is the register-supplied distance.
- R5: The result equals the operand shifted right by the distance, with zeros filling from bit 31. Each loop step moves the data one bit and lowers the counter by one.
- R6: When the chosen distance is zero, the result equals the operand.
- R7: Counting the clock edge that samples start as edge 1, done is 1 after edge n+4, where n is the chosen distance. At that point the counter is zero.
- R8: done is 1 for exactly one clock. On the following clock both busy and done are 0.
- R9: A start pulse that arrives while busy is 1 is ignored. The running operation finishes with its original result and timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin pulse, acted on only while idle |
| imm_dist | input | 5 | Immediate shift distance |
| reg_dist | input | 5 | Register-supplied distance, used when imm_dist is zero |
| operand | input | 32 | Word to shift, held stable while busy |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-clock pulse, result valid |
| result | output | 32 | Shifted word |

## Verification
Two situations are hard to reach from the ports:
- **A start pulse during the loop.** The driver pulses start several clocks into a long loop, and again in the final clock. The scoreboard still expects the original result and latency.
- **The fallback count.** The path where a zero immediate hands over to the register distance is covered with that distance both nonzero and zero. A zero register distance makes a zero-length loop.

Every operation is also timed from the edge that samples start, to confirm the n+4 latency.

// File: rtl/iter_shr_pkg.sv
package iter_shr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PICK  = 3'd1,
    ST_LOAD  = 3'd2,
    ST_SHIFT = 3'd3,
    ST_FIN   = 3'd4
  } shr_state_t;
endpackage

// File: rtl/iter_shr_count.sv
module iter_shr_count #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld,
  input  logic [CNT_W-1:0] ld_val,
  input  logic             dec,
  output logic [CNT_W-1:0] cnt,
  output logic             zero
);
  always_ff @(posedge clk) begin
    if (rst)      cnt <= '0;
    else if (ld)  cnt <= ld_val;
    else if (dec) cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

  // R5: each loop step lowers the count by exactly one
  assert_cnt_step_R5: assert property (@(posedge clk) disable iff (rst)
    (dec && !ld && !zero) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/iter_shr_work.sv
module iter_shr_work #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld,
  input  logic [WIDTH-1:0] ld_val,
  input  logic             shift,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)        q <= '0;
    else if (ld)    q <= ld_val;
    else if (shift) q <= {1'b0, q[WIDTH-1:1]};
  end

  // R5: one-place move with a zero entering at the top
  assert_shift_one_R5: assert property (@(posedge clk) disable iff (rst)
    (shift && !ld) |=> (q == ($past(q) >> 1)));
endmodule

// File: rtl/iter_shr_ctrl.sv
module iter_shr_ctrl
  import iter_shr_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic cnt_zero,
  output logic cnt_ld,
  output logic cnt_from_reg,
  output logic work_ld,
  output logic step,
  output logic busy,
  output logic done
);
  shr_state_t state, nxt;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nxt;
  end

  always_comb begin
    nxt          = state;
    cnt_ld       = 1'b0;
    cnt_from_reg = 1'b0;
    work_ld      = 1'b0;
    step         = 1'b0;
    case (state)
      ST_IDLE: if (start) begin
        cnt_ld = 1'b1;
        nxt    = ST_PICK;
      end
      ST_PICK: begin
        cnt_ld       = cnt_zero;
        cnt_from_reg = 1'b1;
        nxt          = ST_LOAD;
      end
      ST_LOAD: begin
        work_ld = 1'b1;
        nxt     = ST_SHIFT;
      end
      ST_SHIFT: begin
        if (cnt_zero) nxt = ST_FIN;
        else          step = 1'b1;
      end
      ST_FIN:  nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_FIN);

  // R8: completion pulse lasts one clock
  assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R9: an operation in flight is never cut short by a new start
  assert_no_restart_R9: assert property (@(posedge clk) disable iff (rst)
    (busy && !done) |=> busy);
  // R7: completion only once the counter has run out
  assert_done_at_zero_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> cnt_zero);
endmodule

// File: rtl/iter_shr.sv
module iter_shr #(
  parameter int WIDTH = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  input  logic [$clog2(WIDTH)-1:0] imm_dist,
  input  logic [$clog2(WIDTH)-1:0] reg_dist,
  input  logic [WIDTH-1:0]         operand,
  output logic                     busy,
  output logic                     done,
  output logic [WIDTH-1:0]         result
);
  localparam int CNT_W = $clog2(WIDTH);

  logic             cnt_ld, cnt_from_reg, cnt_zero, work_ld, step;
  logic [CNT_W-1:0] cnt_val, cnt_src;

  assign cnt_src = cnt_from_reg ? reg_dist : imm_dist;

  iter_shr_ctrl u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .start        (start),
    .cnt_zero     (cnt_zero),
    .cnt_ld       (cnt_ld),
    .cnt_from_reg (cnt_from_reg),
    .work_ld      (work_ld),
    .step         (step),
    .busy         (busy),
    .done         (done)
  );

  iter_shr_count #(.CNT_W(CNT_W)) u_count (
    .clk    (clk),
    .rst    (rst),
    .ld     (cnt_ld),
    .ld_val (cnt_src),
    .dec    (step),
    .cnt    (cnt_val),
    .zero   (cnt_zero)
  );

  iter_shr_work #(.WIDTH(WIDTH)) u_work (
    .clk    (clk),
    .rst    (rst),
    .ld     (work_ld),
    .ld_val (operand),
    .shift  (step),
    .q      (result)
  );

  // R2: an accepted start always makes the block busy next clock
  assert_start_busy_R2: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);
endmodule

// File: tb/iter_shr_tb.sv
module iter_shr_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        start;
  logic [4:0]  imm_dist, reg_dist;
  logic [31:0] operand;
  logic        busy, done;
  logic [31:0] result;

  always #4 clk = ~clk;

  iter_shr u_dut (
    .clk(clk), .rst(rst), .start(start), .imm_dist(imm_dist),
    .reg_dist(reg_dist), .operand(operand), .busy(busy), .done(done),
    .result(result)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int t0     = 0;
  bit finished = 1'b0;
  logic [31:0] exp_q[$];
  int          lat_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // monitor: compares each completion with the scoreboard head
  always @(negedge clk) begin
    if (!rst && done) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R9 unexpected done", 32'd1, 32'd0);
      end else begin
        logic [31:0] e;
        int          l;
        e = exp_q.pop_front();
        l = lat_q.pop_front();
        check(result == e, "R5/R6 result", result, e);
        check((cyc - t0 + 1) == l, "R7 latency",
              32'(cyc - t0 + 1), 32'(l));
      end
    end
  end

  // driver: one operation, optional stray start pulses while busy
  task automatic run(input logic [31:0] op, input logic [4:0] imm,
                     input logic [4:0] rd, input bit poke, input string tag);
    int n;
    n = (imm != 0) ? int'(imm) : int'(rd);
    @(negedge clk);
    operand = op; imm_dist = imm; reg_dist = rd; start = 1'b1;
    exp_q.push_back(op >> n);
    lat_q.push_back(n + 4);
    @(negedge clk);
    start = 1'b0;
    t0 = cyc;
    check(busy == 1'b1, {"R2 busy after start ", tag}, 32'(busy), 32'd1);
    if (poke) begin
      repeat (3) @(negedge clk);
      start = 1'b1; imm_dist = ~imm;   // R9: stray start mid-loop
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) begin
      if (poke && busy) start = 1'b1;  // R9: also pulse in final clock
      @(negedge clk);
    end
    start = 1'b0;
    @(negedge clk);
    check(!busy && !done, {"R8 idle after done ", tag},
          {30'd0, busy, done}, 32'd0);
  endtask

  initial begin
    rst = 1'b1; start = 1'b0; imm_dist = '0; reg_dist = '0; operand = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!busy && !done && result == 0, "R1 reset state",
          result | {30'd0, busy, done}, 32'd0);
    run(32'hFFFF_FFFF, 5'd31, 5'd0,  1'b0, "max");
    run(32'h8000_0000, 5'd1,  5'd9,  1'b0, "one");
    run(32'hA5A5_A5A5, 5'd7,  5'd31, 1'b0, "R3 reg ignored");
    run(32'h1234_5678, 5'd0,  5'd4,  1'b0, "R4 fallback");
    run(32'hDEAD_BEEF, 5'd0,  5'd0,  1'b0, "R6 zero");
    run(32'hCAFE_F00D, 5'd9,  5'd2,  1'b1, "R9 busy start");
    run(32'h0F0F_0F0F, 5'd0,  5'd17, 1'b1, "R9 fallback busy");
    for (int i = 1; i < 8; i++)
      run(32'h9E37_79B9 * i, 5'(i * 5), 5'(i * 3), 1'b0, "sweep");
    check(exp_q.size() == 0, "R7 all completed", 32'(exp_q.size()), 32'd0);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule